// File: doc/BRIEF.md
# Lockstep Alarm Statistics Counter Bank

This block keeps event statistics for the error controller of a dual-core lockstep pair. Six saturating 4-bit counters record:

- comparator mismatch alarms;
- comparator self-diagnostic alarms;
- timeout alarms;
- self-detection alarms;
- reset-acknowledge edges from either core;
- departures of the system state from DISABLED.

Each counter advances once per new occurrence of its event. The four alarm counters honour per-alarm mask bits. The self-detection counter also stays still while fault injection is active.

Software reads the counts through two 32-bit read-only status words. The reset-acknowledge count and the enable count are each compared against a 4-bit threshold. Each comparison drives a level alarm output. Alarm generation, the comparator and the rest of the register file sit outside this block.

Top module: `lsstat_bank`

## Requirements
- R1: Status word 0 (word_sel_i = 0) carries the mismatch count in bits [3:0] and the self-diagnostic count in bits [19:16]; every other bit reads 0.
- R2: Status word 4 (word_sel_i = 1) carries the enable count in [3:0], the reset-acknowledge count in [11:8], the timeout count in [19:16] and the self-detection count in [23:20]; every other bit reads 0.
- R3: Every counter is 4 bits, clears to 0 on reset and holds at 15 instead of wrapping.
- R4: A counter advances by exactly one per rising edge of its event input, however long the input stays high.
- R5: Mask bits alarm_mask_i[0] (mismatch), [1] (self-diagnostic), [2] (timeout) and [3] (self-detection) each stop their own counter from advancing while set.
- R6: With fault_inject_i high, the mismatch, self-diagnostic and timeout counters still advance (if unmasked), while the self-detection counter does not advance.
- R7: The reset-acknowledge counter advances on a rising edge of rack_left_i or rack_right_i; edges on both in the same cycle add one.
- R8: The enable counter advances when sys_state_i moves from DISABLED (2'b00) to any other value; other state changes leave it unchanged.
- R9: rack_alarm_o is high exactly while the reset-acknowledge count exceeds rack_thr_i, and en_alarm_o exactly while the enable count exceeds en_thr_i; both are low after reset.
- R10: Writes (wr_en_i with any wr_data_i) to either status word leave every count unchanged.
- R11: rd_data_o takes the selected status word on the clock edge that samples rd_en_i high, and holds its value while rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mismatch_i | input | 1 | Comparator mismatch alarm level |
| selfdiag_i | input | 1 | Comparator self-diagnostic alarm level |
| timeout_i | input | 1 | Timeout alarm level |
| selfdet_i | input | 1 | Self-detection alarm level |
| alarm_mask_i | input | 4 | Per-alarm mask bits |
| fault_inject_i | input | 1 | Fault injection in progress |
| rack_left_i | input | 1 | Reset acknowledge, left core |
| rack_right_i | input | 1 | Reset acknowledge, right core |
| sys_state_i | input | 2 | System state, 2'b00 is DISABLED |
| rack_thr_i | input | 4 | Reset-acknowledge alarm threshold |
| en_thr_i | input | 4 | Enable alarm threshold |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (ignored) |
| word_sel_i | input | 1 | 0 selects status word 0, 1 selects status word 4 |
| wr_data_i | input | 32 | Write data (ignored) |
| rd_data_o | output | 32 | Registered read data |
| rack_alarm_o | output | 1 | Reset-acknowledge count above threshold |
| en_alarm_o | output | 1 | Enable count above threshold |

## Verification
The bound checker watches several properties on every cycle:

- no counter moves by more than one step;
- a counter at 15 stays at 15;
- a masked mismatch alarm, a quiet reset-acknowledge pair or a DISABLED state freezes its count;
- read data holds when no read is strobed;
- a rising reset alarm under a steady threshold comes with a fresh count.

Some properties only the bench scenarios can show. These are the exact field placement in both words, the fault-injection exception for self-detection, and the single increment for simultaneous edges. They also include the threshold crossing points and the absence of any effect from writes, each compared against a reference model through the read port.

// File: rtl/lsstat_pkg.sv
package lsstat_pkg;
    parameter int CNT_W   = 4;
    parameter int DATA_W  = 32;
    parameter int ST_W    = 2;
    parameter int NUM_ALM = 4;
    parameter int NUM_CTR = 6;

    localparam logic [ST_W-1:0] ST_DISABLED = '0;

    // counter indices; alarm inputs share indices 0..3
    localparam int CTR_MIS  = 0;
    localparam int CTR_DIAG = 1;
    localparam int CTR_TMO  = 2;
    localparam int CTR_SDET = 3;
    localparam int CTR_RACK = 4;
    localparam int CTR_EN   = 5;

    // field offsets inside the status words
    localparam int W0_MIS  = 0;
    localparam int W0_DIAG = 16;
    localparam int W4_EN   = 0;
    localparam int W4_RACK = 8;
    localparam int W4_TMO  = 16;
    localparam int W4_SDET = 20;

    typedef struct packed {
        logic [ST_W-1:0]   sys_prev;
        logic [DATA_W-1:0] rdata;
    } bank_regs_t;
endpackage

// File: rtl/lsstat_edge.sv
module lsstat_edge #(
    parameter int N = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/lsstat_satctr.sv
module lsstat_satctr #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = '1;
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lsstat_bank.sv
module lsstat_bank
    import lsstat_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                mismatch_i,
    input  logic                selfdiag_i,
    input  logic                timeout_i,
    input  logic                selfdet_i,
    input  logic [NUM_ALM-1:0]  alarm_mask_i,
    input  logic                fault_inject_i,
    input  logic                rack_left_i,
    input  logic                rack_right_i,
    input  logic [ST_W-1:0]     sys_state_i,
    input  logic [CNT_W-1:0]    rack_thr_i,
    input  logic [CNT_W-1:0]    en_thr_i,
    input  logic                rd_en_i,
    input  logic                wr_en_i,
    input  logic                word_sel_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                rack_alarm_o,
    output logic                en_alarm_o
);
    localparam int EDGE_N = NUM_ALM + 2;

    bank_regs_t regs_d, regs_q;
    logic [EDGE_N-1:0]              lvl, rise;
    logic [NUM_CTR-1:0]             inc;
    logic [NUM_CTR-1:0][CNT_W-1:0]  cnt;
    logic [DATA_W-1:0]              word0, word4;
    logic [CNT_W-1:0]               mis_cnt, rack_cnt, en_cnt;
    logic                           unused_wr;

    // the write side is accepted and discarded: the status words are read-only
    assign unused_wr = ^{wr_en_i, wr_data_i};

    assign lvl = {rack_right_i, rack_left_i, selfdet_i, timeout_i, selfdiag_i, mismatch_i};

    lsstat_edge #(.N(EDGE_N)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl),
        .rise_o (rise)
    );

    always_comb begin
        inc           = '0;
        inc[CTR_MIS]  = rise[CTR_MIS]  & ~alarm_mask_i[CTR_MIS];
        inc[CTR_DIAG] = rise[CTR_DIAG] & ~alarm_mask_i[CTR_DIAG];
        inc[CTR_TMO]  = rise[CTR_TMO]  & ~alarm_mask_i[CTR_TMO];
        inc[CTR_SDET] = rise[CTR_SDET] & ~alarm_mask_i[CTR_SDET] & ~fault_inject_i;
        inc[CTR_RACK] = rise[NUM_ALM] | rise[NUM_ALM+1];
        inc[CTR_EN]   = (regs_q.sys_prev == ST_DISABLED) && (sys_state_i != ST_DISABLED);
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        lsstat_satctr #(.W(CNT_W)) u_ctr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .inc_i  (inc[g]),
            .cnt_o  (cnt[g])
        );
    end

    always_comb begin
        word0 = '0;
        word0[W0_MIS  +: CNT_W] = cnt[CTR_MIS];
        word0[W0_DIAG +: CNT_W] = cnt[CTR_DIAG];
        word4 = '0;
        word4[W4_EN   +: CNT_W] = cnt[CTR_EN];
        word4[W4_RACK +: CNT_W] = cnt[CTR_RACK];
        word4[W4_TMO  +: CNT_W] = cnt[CTR_TMO];
        word4[W4_SDET +: CNT_W] = cnt[CTR_SDET];

        regs_d          = regs_q;
        regs_d.sys_prev = sys_state_i;
        if (rd_en_i) regs_d.rdata = word_sel_i ? word4 : word0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q.sys_prev <= ST_DISABLED;
            regs_q.rdata    <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mis_cnt      = cnt[CTR_MIS];
    assign rack_cnt     = cnt[CTR_RACK];
    assign en_cnt       = cnt[CTR_EN];
    assign rd_data_o    = regs_q.rdata;
    assign rack_alarm_o = rack_cnt > rack_thr_i;
    assign en_alarm_o   = en_cnt > en_thr_i;
endmodule

module lsstat_bank_chk
    import lsstat_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_ALM-1:0] alarm_mask_i,
    input logic               rack_left_i,
    input logic               rack_right_i,
    input logic [ST_W-1:0]    sys_state_i,
    input logic [CNT_W-1:0]   rack_thr_i,
    input logic               rd_en_i,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic               rack_alarm_o,
    input logic [CNT_W-1:0]   mis_cnt,
    input logic [CNT_W-1:0]   rack_cnt,
    input logic [CNT_W-1:0]   en_cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    a_r3_no_wrap_mis: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mis_cnt == CMAX) |=> (mis_cnt == CMAX));

    a_r3_no_wrap_rack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rack_cnt == CMAX) |=> (rack_cnt == CMAX));

    a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((mis_cnt == $past(mis_cnt)) || (mis_cnt == $past(mis_cnt) + 1'b1)));

    a_r5_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alarm_mask_i[CTR_MIS] |=> $stable(mis_cnt));

    a_r7_quiet_rack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rack_left_i && !rack_right_i) |=> $stable(rack_cnt));

    a_r8_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sys_state_i == ST_DISABLED) |=> $stable(en_cnt));

    a_r9_alarm_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(rack_alarm_o) && $stable(rack_thr_i)) |-> (rack_cnt != $past(rack_cnt)));

    a_r11_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));
endmodule

bind lsstat_bank lsstat_bank_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alarm_mask_i (alarm_mask_i),
    .rack_left_i  (rack_left_i),
    .rack_right_i (rack_right_i),
    .sys_state_i  (sys_state_i),
    .rack_thr_i   (rack_thr_i),
    .rd_en_i      (rd_en_i),
    .rd_data_o    (rd_data_o),
    .rack_alarm_o (rack_alarm_o),
    .mis_cnt      (mis_cnt),
    .rack_cnt     (rack_cnt),
    .en_cnt       (en_cnt)
);

// File: tb/lsstat_bank_tb_top.sv
module lsstat_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  alm = '0;
    logic [3:0]  mask = '0;
    logic        inject = 1'b0;
    logic        rl = 1'b0, rr = 1'b0;
    logic [1:0]  st = 2'b00;
    logic [3:0]  rthr = 4'd2, ethr = 4'd1;
    logic        rd_en = 1'b0, wr_en = 1'b0, sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ralarm, ealarm;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m [6] = '{0, 0, 0, 0, 0, 0};

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    lsstat_bank dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .mismatch_i(alm[0]), .selfdiag_i(alm[1]), .timeout_i(alm[2]), .selfdet_i(alm[3]),
        .alarm_mask_i(mask), .fault_inject_i(inject),
        .rack_left_i(rl), .rack_right_i(rr), .sys_state_i(st),
        .rack_thr_i(rthr), .en_thr_i(ethr),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .word_sel_i(sel), .wr_data_i(wdata),
        .rd_data_o(rdata), .rack_alarm_o(ralarm), .en_alarm_o(ealarm)
    );

    function automatic int sat(input int v);
        return (v > 15) ? 15 : v;
    endfunction

    function automatic logic [31:0] w0();
        return {12'h000, 4'(m[1]), 12'h000, 4'(m[0])};
    endfunction

    function automatic logic [31:0] w4();
        return {8'h00, 4'(m[3]), 4'(m[2]), 4'h0, 4'(m[4]), 4'h0, 4'(m[5])};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: issue a read and push the model's expectation
    task automatic rd_word(input logic s, input string tag);
        item_t it;
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        it.exp = s ? w4() : w0();
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compare registered read data one edge after the strobe
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                item_t it;
                @(negedge clk);
                it = sbq.pop_front();
                chk(it.tag, rdata, it.exp);
            end
        end
    end

    task automatic pulse_alarm(input int idx, input int hold);
        @(negedge clk);
        alm[idx] = 1'b1;
        if (!mask[idx] && !(idx == 3 && inject)) m[idx] = sat(m[idx] + 1);
        repeat (hold) @(negedge clk);
        alm[idx] = 1'b0;
    endtask

    task automatic rack_edge(input logic l, input logic r);
        @(negedge clk);
        rl = l; rr = r;
        m[4] = sat(m[4] + 1);
        @(negedge clk);
        rl = 1'b0; rr = 1'b0;
    endtask

    task automatic set_state(input logic [1:0] ns);
        @(negedge clk);
        if (st == 2'b00 && ns != 2'b00) m[5] = sat(m[5] + 1);
        st = ns;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset alarms", {30'h0, ralarm, ealarm}, 32'h0);
        rst_n = 1'b1;
        rd_word(1'b0, "R3 reset word0");
        rd_word(1'b1, "R3 reset word4");

        // R4: held alarm counts once
        pulse_alarm(0, 3);
        rd_word(1'b0, "R4 held mismatch once");
        pulse_alarm(1, 1);
        pulse_alarm(1, 2);
        rd_word(1'b0, "R1 self-diag field");
        pulse_alarm(2, 1);
        pulse_alarm(3, 1);
        rd_word(1'b1, "R2 timeout and self-detect fields");

        // R5: masked alarms do not count
        mask = 4'hF;
        for (int i = 0; i < 4; i++) pulse_alarm(i, 1);
        rd_word(1'b0, "R5 masked word0");
        rd_word(1'b1, "R5 masked word4");
        mask = 4'h0;

        // R6: injection path
        @(negedge clk); inject = 1'b1;
        for (int i = 0; i < 4; i++) pulse_alarm(i, 1);
        @(negedge clk); inject = 1'b0;
        rd_word(1'b0, "R6 inject word0");
        rd_word(1'b1, "R6 inject word4");

        // R7 and R9: reset-acknowledge edges against threshold 2
        rack_edge(1'b1, 1'b0);
        rack_edge(1'b0, 1'b1);
        @(negedge clk);
        chk("R9 rack alarm at count 2", {31'h0, ralarm}, 32'h0);
        rack_edge(1'b1, 1'b1);
        rd_word(1'b1, "R7 simultaneous edges count one");
        chk("R9 rack alarm at count 3", {31'h0, ralarm}, 32'h1);

        // R8 and R9: leaving DISABLED, threshold 1
        set_state(2'b01);
        set_state(2'b10);
        @(negedge clk);
        chk("R9 enable alarm at count 1", {31'h0, ealarm}, 32'h0);
        set_state(2'b00);
        set_state(2'b11);
        rd_word(1'b1, "R8 enable count");
        chk("R9 enable alarm at count 2", {31'h0, ealarm}, 32'h1);
        set_state(2'b00);

        // R10: writes ignored
        @(negedge clk); wr_en = 1'b1; wdata = 32'hFFFF_FFFF; sel = 1'b0;
        @(negedge clk); sel = 1'b1;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
        rd_word(1'b0, "R10 word0 after write");
        rd_word(1'b1, "R10 word4 after write");

        // R3: saturation
        for (int i = 0; i < 20; i++) pulse_alarm(0, 1);
        for (int i = 0; i < 20; i++) rack_edge(1'b1, 1'b0);
        rd_word(1'b0, "R3 mismatch saturates");
        rd_word(1'b1, "R3 rack saturates");

        // R11: read data holds without a strobe
        pulse_alarm(1, 1);
        @(negedge clk);
        chk("R11 read data held", rdata, w4());
        rd_word(1'b0, "R11 fresh read");

        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule